// File: doc/BRIEF.md
# Batched Multi-Sector Flash Erase Issuer

This block sits on the host side of an asynchronous parallel NOR flash bus. It accepts sector numbers through a small internal FIFO. Each entry carries a flag that marks the final sector of a batch. From these entries it builds a single batched sector erase on the bus. The first sector of a batch gets the full six-write command sequence. Every further sector gets a single write that carries the sector address and the erase command. No other command is placed between them, because any foreign command would abort the whole erase.

Once the device sees the last write, it waits a short acceptance window before it starts erasing, and any sector written after that window is lost. The issuer therefore counts clock cycles between write strobes. If the FIFO runs dry for too long, it stops issuing writes and raises a gap error. It then drops the rest of that batch.

After the final sector, the issuer reads status repeatedly and watches the toggle bit, which is data bit 6. Two reads in a row with the same bit 6 value mean the erase has finished, and the block then pulses `done`. Strobe setup, pulse width and recovery are set as clock-cycle counts by parameters.

Top module: `sector_erase_issuer`

## Requirements
- R1: The first sector of a batch is issued as six bus writes in this order (address/data, hex): 555/AA, 2AA/55, 555/80, 555/AA, 2AA/55, then the sector base address with data 30. The sector base address is the sector number shifted left by AW-SW bits.
- R2: Each further sector of the same batch is issued as exactly one write of its sector base address with data 30, in FIFO order, with no other writes in between.
- R3: Within a batch, the distance between consecutive rising edges of `fl_we_n` never exceeds GAP_MAX clock cycles.
- R4: For every write, `fl_ce_n` is low with address and data valid for T_SU cycles before `fl_we_n` falls. `fl_we_n` then stays low for exactly T_WP cycles, and address and data do not change while it is low.
- R5: The FIFO holds DEPTH entries. `in_ready` is low while it is full, and a push offered while `in_ready` is low is ignored. `in_last`=1 marks the final sector of a batch.
- R6: After the final sector write, the block reads status at that sector's base address with `fl_oe_n` and `fl_ce_n` low for T_RD cycles and samples bit 6 in the last of them. It pulses `done` when two consecutive reads return the same bit 6. A device that toggles for B reads and then holds therefore sees B+1 reads.
- R7: If the FIFO stays empty until one more write would break R3, `gap_err` rises, no further write is issued, and polling starts. The remaining entries of that batch, up to and including the one marked last, are then dropped without any bus activity.
- R8: `done` is a single-cycle pulse. `gap_err` stays high until the next batch starts, and is then cleared.
- R9: After reset, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are high, `fl_dq_oe`, `done` and `gap_err` are low, and `in_ready` is high.
- R10: `fl_we_n` and `fl_oe_n` are never low together, and `fl_we_n` is low only while `fl_ce_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sector push request |
| in_sector | input | SW | Sector number to erase |
| in_last | input | 1 | Marks the final sector of a batch |
| in_ready | output | 1 | FIFO can accept a sector |
| fl_addr | output | AW | Flash address |
| fl_dq_out | output | 8 | Write data to flash |
| fl_dq_oe | output | 1 | Drive enable for write data |
| fl_dq_in | input | 8 | Read data from flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| busy | output | 1 | A batch or poll is in progress |
| done | output | 1 | One-cycle pulse when erase completes |
| gap_err | output | 1 | A batch was cut short by an empty FIFO |

## Verification
The assertions assume that `fl_dq_in` is held steady for the whole of each read strobe. The bench flash model keeps this assumption by changing its status value only after `fl_oe_n` returns high. The window check also assumes that every batch ends in a polling read, which is what clears its notion of "inside a batch". The bench never pushes while a gap is being measured, except on purpose in the gap-error scenario. It offers pushes only when `in_ready` is high, except for the one deliberate push into a full FIFO.

// File: rtl/sector_erase_issuer.sv
module sector_erase_issuer #(
  parameter int AW      = 22,
  parameter int SW      = 6,
  parameter int DEPTH   = 4,
  parameter int T_SU    = 2,
  parameter int T_WP    = 8,
  parameter int T_WH    = 4,
  parameter int T_RD    = 6,
  parameter int GAP_MAX = 8000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [SW-1:0] in_sector,
  input  logic          in_last,
  output logic          in_ready,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_in,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic          busy,
  output logic          done,
  output logic          gap_err
);

  localparam int PW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int TW      = $clog2(GAP_MAX + 1) + 1;
  localparam int OW      = AW - SW;
  localparam int GAP_LIM = GAP_MAX - T_SU - T_WP - 1;

  typedef enum logic [2:0] {S_IDLE, S_SU, S_WP, S_WH, S_WAIT, S_RD, S_RG} st_t;

  st_t            st;
  logic [TW-1:0]  tmr, gap_cnt;
  logic [2:0]     step;
  logic [SW-1:0]  cur_sec;
  logic           cur_last, discard, prev_tog, have_prev;

  logic [SW:0]    mem [DEPTH];
  logic [PW-1:0]  wr_ptr, rd_ptr;
  logic [PW:0]    count;
  logic           empty, push, pop, hd_last;
  logic [SW-1:0]  hd_sec;

  assign empty    = (count == '0);
  assign in_ready = (count != (PW+1)'(DEPTH));
  assign push     = in_valid && in_ready;
  assign hd_sec   = mem[rd_ptr][SW-1:0];
  assign hd_last  = mem[rd_ptr][SW];
  assign pop      = (st == S_IDLE && discard && !empty)
                 || (st == S_WH && tmr == '0 && step == 3'd4)
                 || (st == S_WAIT && !empty);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {in_last, in_sector};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tmr       <= '0;
      gap_cnt   <= '0;
      step      <= '0;
      cur_sec   <= '0;
      cur_last  <= 1'b0;
      discard   <= 1'b0;
      prev_tog  <= 1'b0;
      have_prev <= 1'b0;
      done      <= 1'b0;
      gap_err   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_WP && tmr == '0)        gap_cnt <= '0;
      else if (gap_cnt != TW'(GAP_MAX))   gap_cnt <= gap_cnt + 1'b1;
      case (st)
        S_IDLE: if (!empty) begin
          if (discard) begin
            if (hd_last) discard <= 1'b0;
          end else begin
            gap_err <= 1'b0;
            step    <= '0;
            st      <= S_SU;
            tmr     <= TW'(T_SU - 1);
          end
        end
        S_SU: if (tmr == '0) begin
          st  <= S_WP;
          tmr <= TW'(T_WP - 1);
        end else tmr <= tmr - 1'b1;
        S_WP: if (tmr == '0) begin
          st  <= S_WH;
          tmr <= TW'(T_WH - 1);
        end else tmr <= tmr - 1'b1;
        S_WH: if (tmr == '0) begin
          if (step != 3'd5) begin
            step <= step + 1'b1;
            st   <= S_SU;
            tmr  <= TW'(T_SU - 1);
            if (step == 3'd4) begin
              cur_sec  <= hd_sec;
              cur_last <= hd_last;
            end
          end else if (cur_last) begin
            st        <= S_RD;
            tmr       <= TW'(T_RD - 1);
            have_prev <= 1'b0;
          end else st <= S_WAIT;
        end else tmr <= tmr - 1'b1;
        S_WAIT: if (!empty) begin
          cur_sec  <= hd_sec;
          cur_last <= hd_last;
          st       <= S_SU;
          tmr      <= TW'(T_SU - 1);
        end else if (gap_cnt >= TW'(GAP_LIM)) begin
          gap_err   <= 1'b1;
          discard   <= 1'b1;
          st        <= S_RD;
          tmr       <= TW'(T_RD - 1);
          have_prev <= 1'b0;
        end
        S_RD: if (tmr == '0) begin
          if (have_prev && fl_dq_in[6] == prev_tog) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            prev_tog  <= fl_dq_in[6];
            have_prev <= 1'b1;
            st        <= S_RG;
          end
        end else tmr <= tmr - 1'b1;
        S_RG: begin
          st  <= S_RD;
          tmr <= TW'(T_RD - 1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign fl_ce_n  = !(st == S_SU || st == S_WP || st == S_RD);
  assign fl_we_n  = (st != S_WP);
  assign fl_oe_n  = (st != S_RD);
  assign fl_dq_oe = (st == S_SU || st == S_WP || st == S_WH);
  assign busy     = (st != S_IDLE);

  always_comb begin
    fl_addr   = {cur_sec, {OW{1'b0}}};
    fl_dq_out = 8'h30;
    if (st != S_RD && st != S_RG) begin
      case (step)
        3'd0, 3'd3: begin fl_addr = AW'(12'h555); fl_dq_out = 8'hAA; end
        3'd1, 3'd4: begin fl_addr = AW'(12'h2AA); fl_dq_out = 8'h55; end
        3'd2:       begin fl_addr = AW'(12'h555); fl_dq_out = 8'h80; end
        default:    ;
      endcase
    end
  end

  logic [TW-1:0] wp_chk, gap_chk;
  logic          in_batch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_chk   <= '0;
      gap_chk  <= '0;
      in_batch <= 1'b0;
    end else begin
      wp_chk <= fl_we_n ? '0 : wp_chk + 1'b1;
      if (fl_we_n && wp_chk != '0)           gap_chk <= '0;
      else if (gap_chk != TW'(GAP_MAX + 1))  gap_chk <= gap_chk + 1'b1;
      if (!fl_oe_n)                          in_batch <= 1'b0;
      else if (fl_we_n && wp_chk != '0)      in_batch <= 1'b1;
    end
  end

  // R10
  no_strobe_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));
  // R10
  we_inside_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> !fl_ce_n);
  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> ($stable(fl_addr) && $stable(fl_dq_out)));
  // R4
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we_n && wp_chk != '0) |-> (wp_chk == TW'(T_WP)));
  // R3
  gap_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we_n && wp_chk != '0 && in_batch) |-> (gap_chk < TW'(GAP_MAX)));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/sector_erase_issuer_tb.sv
`timescale 1ns/1ps
module sector_erase_issuer_tb_top;
  localparam int AW = 22, SW = 6, DEPTH = 4;
  localparam int T_SU = 2, T_WP = 8, T_WH = 4, T_RD = 6, GAP = 400;
  localparam int OW = AW - SW;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, in_ready;
  logic [SW-1:0] in_sector = '0;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_dq_out, fl_dq_in;
  logic fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n, busy, done, gap_err;

  always #2.5 clk = ~clk;

  sector_erase_issuer #(.AW(AW), .SW(SW), .DEPTH(DEPTH), .T_SU(T_SU), .T_WP(T_WP),
    .T_WH(T_WH), .T_RD(T_RD), .GAP_MAX(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sector(in_sector),
    .in_last(in_last), .in_ready(in_ready), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
    .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
    .fl_oe_n(fl_oe_n), .busy(busy), .done(done), .gap_err(gap_err));

  int checks = 0, fails = 0, cyc = 0;
  int nw = 0, reads = 0, busy_reads = 3, su_run = 0, wp_run = 0, su_seen = 0;
  int last_rise = 0, max_gap = 0, lastr_addr = 0;
  bit inb = 0, prev_we = 1, prev_oe = 1;
  logic [AW-1:0] wa [64];
  logic [7:0]    wd [64];
  logic tog;

  assign tog = (reads < busy_reads) ? reads[0] : 1'(busy_reads - 1);
  assign fl_dq_in = {1'b0, tog, 6'b0};

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!fl_we_n && prev_we) su_seen = su_run;
      if (fl_we_n && !prev_we) begin
        chk(su_seen == T_SU, "R4 setup", su_seen, T_SU);
        chk(wp_run == T_WP, "R4 width", wp_run, T_WP);
        if (inb && cyc - last_rise > max_gap) max_gap = cyc - last_rise;
        last_rise = cyc; inb = 1; reads = 0;
        if (nw < 64) begin wa[nw] = fl_addr; wd[nw] = fl_dq_out; end
        nw++; wp_run = 0;
      end
      if (!fl_we_n) wp_run++;
      if (!fl_ce_n && fl_we_n) su_run++; else if (fl_ce_n) su_run = 0;
      if (!fl_oe_n) begin inb = 0; lastr_addr = int'(fl_addr); end
      if (fl_oe_n && !prev_oe) reads++;
      prev_we = fl_we_n; prev_oe = fl_oe_n;
    end
  end

  initial begin
    while (cyc < 150000) @(negedge clk);
    chk(0, "watchdog", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic push(input int s, input bit l);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_sector = SW'(s); in_last = l;
    @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  task automatic wait_done(input string tag);
    int t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk(done, tag, done, 1);
    @(negedge clk);
  endtask

  task automatic exp_first(input int base, input int s, input string tag);
    chk(wa[base] == 22'h555 && wd[base] == 8'hAA, tag, {wa[base], wd[base]}, {22'h555, 8'hAA});
    chk(wa[base+1] == 22'h2AA && wd[base+1] == 8'h55, tag, {wa[base+1], wd[base+1]}, {22'h2AA, 8'h55});
    chk(wa[base+2] == 22'h555 && wd[base+2] == 8'h80, tag, {wa[base+2], wd[base+2]}, {22'h555, 8'h80});
    chk(wa[base+3] == 22'h555 && wd[base+3] == 8'hAA, tag, {wa[base+3], wd[base+3]}, {22'h555, 8'hAA});
    chk(wa[base+4] == 22'h2AA && wd[base+4] == 8'h55, tag, {wa[base+4], wd[base+4]}, {22'h2AA, 8'h55});
    exp_sec(base + 5, s, tag);
  endtask

  task automatic exp_sec(input int i, input int s, input string tag);
    logic [AW-1:0] a;
    a = AW'(s) << OW;
    chk(wa[i] == a && wd[i] == 8'h30, tag, {wa[i], wd[i]}, {a, 8'h30});
  endtask

  task automatic t_reset;
    chk(fl_ce_n && fl_we_n && fl_oe_n, "R9 strobes", {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
    chk(!fl_dq_oe && !done && !gap_err, "R9 flags", {fl_dq_oe, done, gap_err}, 0);
    chk(in_ready, "R9 in_ready", in_ready, 1);
  endtask

  task automatic t_single;
    nw = 0; busy_reads = 3;
    push(9, 1);
    wait_done("R6 done single");
    chk(nw == 6, "R1 write count", nw, 6);
    exp_first(0, 9, "R1 sequence");
    chk(reads == busy_reads + 1, "R6 read count", reads, busy_reads + 1);
    chk(lastr_addr == (9 << OW), "R6 poll address", lastr_addr, 9 << OW);
    chk(!done, "R8 done pulse", done, 0);
  endtask

  task automatic t_multi;
    nw = 0; max_gap = 0; busy_reads = 1;
    push(3, 0); push(62, 0); push(17, 1);
    wait_done("R6 done multi");
    chk(nw == 8, "R2 write count", nw, 8);
    exp_first(0, 3, "R1 multi first");
    exp_sec(6, 62, "R2 second sector");
    exp_sec(7, 17, "R2 third sector");
    chk(max_gap <= GAP, "R3 gap", max_gap, GAP);
    chk(reads == 2, "R6 read count immediate", reads, 2);
  endtask

  task automatic t_fifo_full;
    int t = 0;
    nw = 0; busy_reads = 60;
    push(5, 1);
    while (fl_oe_n && t < 2000) begin @(negedge clk); t++; end
    push(7, 0); push(8, 0); push(9, 0); push(10, 1);
    chk(!in_ready, "R5 full", in_ready, 0);
    in_valid = 1; in_sector = 11; in_last = 1;
    @(negedge clk);
    in_valid = 0; in_last = 0;
    wait_done("R6 done batch A");
    busy_reads = 2;
    wait_done("R6 done batch B");
    repeat (100) @(negedge clk);
    chk(nw == 15, "R5 ignored push", nw, 15);
    exp_first(6, 7, "R1 batch B");
    exp_sec(12, 8, "R2 batch B");
    exp_sec(13, 9, "R2 batch B");
    exp_sec(14, 10, "R2 batch B");
    chk(in_ready && !busy, "R5 drained", {in_ready, busy}, 2'b10);
  endtask

  task automatic t_gap;
    nw = 0; busy_reads = 2;
    push(12, 0);
    wait_done("R7 done after gap");
    chk(gap_err, "R7 gap_err", gap_err, 1);
    chk(nw == 6, "R7 writes stop", nw, 6);
    push(13, 0); push(14, 1);
    repeat (200) @(negedge clk);
    chk(nw == 6 && !busy, "R7 dropped", nw, 6);
    chk(in_ready, "R7 fifo emptied", in_ready, 1);
    chk(gap_err, "R8 gap_err holds", gap_err, 1);
    push(20, 1);
    repeat (3) @(negedge clk);
    chk(!gap_err, "R8 gap_err clears", gap_err, 0);
    wait_done("R8 next batch done");
    chk(nw == 12, "R8 next batch writes", nw, 12);
    exp_first(6, 20, "R1 after error");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_fifo_full();
    t_gap();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule